// File: doc/BRIEF.md
# Resolver Position Serial Readout Port

This block is the serial read side of a resolver-to-digital converter. A sample strobe copies the current angle word, the current speed word and two fault flags into a holding register. A host then asserts a read select and clocks a 16-bit frame out of a single data pin with its own serial clock. The frame carries the chosen 12-bit word, most significant bit first. An echo of the word selector, the signal-degradation flag, the tracking-loss flag and an odd parity bit follow the word.

The serial clock is asynchronous to the system clock. It passes through a synchronizer, and the frame advances one bit on each falling edge that the synchronizer detects. The output enable follows the read select, so a board-level tri-state buffer can share the data line among several devices. After reset the held angle is zero and both fault flags read low. They keep reading low until the first sample strobe loads the live fault state. Releasing the read select part-way through a frame discards that frame, and the next read starts again at the MSB.

Top module: `rdc_serial_port`

## Requirements
- R1: While reset is high and in the cycle after it falls, `sdo_oe_o` and `sdo_o` are 0. Until the first sample, the held angle and speed words are 0x000.
- R2: The frame is sent in this bit order: word bits 11 down to 0, then the selector echo, then the signal-degradation flag, then the tracking-loss flag, then parity. The frame is 16 bits long.
- R3: If `use_vel_i` is 1 when the read starts, the held speed word is sent and the echo bit is 1. If it is 0, the held angle word is sent and the echo bit is 0.
- R4: The parity bit makes the total number of ones in the 16-bit frame odd.
- R5: `sdo_oe_o` is 1 exactly in the cycles that follow a cycle with `rd_sel_i` high. Whenever `sdo_oe_o` is 0, `sdo_o` is 0.
- R6: The MSB is on `sdo_o` one clock after `rd_sel_i` rises, before any serial clock edge. Each falling edge of `sclk_i` moves to the next bit three system clocks later. Rising edges of `sclk_i` do not change the output.
- R7: After reset, both fault flags in the holding register read 0 until the first `sample_i` pulse. From that pulse on, they hold the values of `sig_fault_i` and `trk_fault_i` captured at each sample.
- R8: A sample taken during a read does not change the frame in progress. The next read sends the newly sampled values.
- R9: If `rd_sel_i` is released mid-frame, the frame is discarded, and the next read starts again from the MSB.
- R10: After all 16 bits have been shifted out, `sdo_o` stays 0 until the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 1 | Capture strobe for words and flags |
| rd_sel_i | input | 1 | Read select, active high, synchronous to clk |
| use_vel_i | input | 1 | 1 selects the speed word, 0 the angle word |
| sclk_i | input | 1 | Asynchronous serial clock from the host |
| pos_word_i | input | 12 | Live angle word |
| vel_word_i | input | 12 | Live speed word |
| sig_fault_i | input | 1 | Live signal-degradation flag |
| trk_fault_i | input | 1 | Live tracking-loss flag |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Output enable for an external tri-state driver |

## Verification
Frames are read in five conditions:
- right after reset with nonzero live inputs, which separates held from live data and tests the forced-low flags;
- with the angle word and with the speed word, which separates the selector path and the echo bit;
- with an all-ones word and both flags high, and with sparse patterns, which exposes a parity that is even or that covers the wrong bits;
- with a sample taken mid-frame, which shows whether the frame is copied at the start of the read;
- with a read aborted after a few bits, which shows whether the bit pointer restarts.

Every serial clock edge is checked, so a shift on the rising edge, or two shifts per period, gives a wrong bit.

// File: rtl/rdc_serial_pkg.sv
package rdc_serial_pkg;

    localparam int unsigned WORD_W  = 12;
    localparam int unsigned TAIL_W  = 4;
    localparam int unsigned FRAME_W = WORD_W + TAIL_W;

    typedef struct packed {
        logic [WORD_W-1:0] pos;
        logic [WORD_W-1:0] vel;
        logic              sig_flag;
        logic              trk_flag;
    } hold_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              vel_echo;
        logic              sig_flag;
        logic              trk_flag;
        logic              parity;
    } frame_t;

    function automatic logic odd_par(input logic [FRAME_W-2:0] bits);
        return ~(^bits);
    endfunction

    function automatic frame_t make_frame(input hold_t h, input logic use_vel);
        frame_t f;
        f.word     = use_vel ? h.vel : h.pos;
        f.vel_echo = use_vel;
        f.sig_flag = h.sig_flag;
        f.trk_flag = h.trk_flag;
        f.parity   = odd_par({f.word, f.vel_echo, f.sig_flag, f.trk_flag});
        return f;
    endfunction

endpackage

// File: rtl/rdc_sclk_sync.sv
module rdc_sclk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    output logic fall_o
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], sclk_i};
        end
    end

    assign fall_o = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/rdc_hold_reg.sv
module rdc_hold_reg
    import rdc_serial_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_i,
    input  logic [WORD_W-1:0] pos_word_i,
    input  logic [WORD_W-1:0] vel_word_i,
    input  logic              sig_fault_i,
    input  logic              trk_fault_i,
    output hold_t             hold_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_o <= '0;
        end else if (sample_i) begin
            hold_o.pos      <= pos_word_i;
            hold_o.vel      <= vel_word_i;
            hold_o.sig_flag <= sig_fault_i;
            hold_o.trk_flag <= trk_fault_i;
        end
    end
endmodule

// File: rtl/rdc_frame_shifter.sv
module rdc_frame_shifter
    import rdc_serial_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_sel_i,
    input  logic  use_vel_i,
    input  hold_t hold_i,
    input  logic  fall_i,
    output logic  sdo_o,
    output logic  oe_o
);
    logic               active;
    logic [FRAME_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sreg   <= '0;
        end else if (!rd_sel_i) begin
            active <= 1'b0;
            sreg   <= '0;
        end else if (!active) begin
            active <= 1'b1;
            sreg   <= make_frame(hold_i, use_vel_i);
        end else if (fall_i) begin
            sreg   <= {sreg[FRAME_W-2:0], 1'b0};
        end
    end

    assign sdo_o = active & sreg[FRAME_W-1];
    assign oe_o  = active;
endmodule

// File: rtl/rdc_serial_port.sv
module rdc_serial_port
    import rdc_serial_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_i,
    input  logic              rd_sel_i,
    input  logic              use_vel_i,
    input  logic              sclk_i,
    input  logic [WORD_W-1:0] pos_word_i,
    input  logic [WORD_W-1:0] vel_word_i,
    input  logic              sig_fault_i,
    input  logic              trk_fault_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    hold_t hold_q;
    logic  sclk_fall;

    rdc_sclk_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (sclk_i),
        .fall_o (sclk_fall)
    );

    rdc_hold_reg i_hold (
        .clk         (clk),
        .rst         (rst),
        .sample_i    (sample_i),
        .pos_word_i  (pos_word_i),
        .vel_word_i  (vel_word_i),
        .sig_fault_i (sig_fault_i),
        .trk_fault_i (trk_fault_i),
        .hold_o      (hold_q)
    );

    rdc_frame_shifter i_shift (
        .clk       (clk),
        .rst       (rst),
        .rd_sel_i  (rd_sel_i),
        .use_vel_i (use_vel_i),
        .hold_i    (hold_q),
        .fall_i    (sclk_fall),
        .sdo_o     (sdo_o),
        .oe_o      (sdo_oe_o)
    );
endmodule

// File: rtl/rdc_serial_port_chk.sv
module rdc_serial_port_chk
    import rdc_serial_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  sample_i,
    input logic  rd_sel_i,
    input logic  sdo_o,
    input logic  sdo_oe_o,
    input logic  sclk_fall,
    input hold_t hold_q
);
    logic seen_sample;

    always_ff @(posedge clk) begin
        if (rst) seen_sample <= 1'b0;
        else if (sample_i) seen_sample <= 1'b1;
    end

    // R5: enable follows read select one cycle later
    assert_oe_on_R5: assert property (@(posedge clk) disable iff (rst)
        rd_sel_i |=> sdo_oe_o);
    // R9: release ends the read on the next cycle
    assert_oe_off_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_sel_i |=> !sdo_oe_o);
    // R5: line quiet while not enabled
    assert_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe_o |-> !sdo_o);
    // R6: no bit change without a detected falling edge
    assert_hold_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (sdo_oe_o && $past(sdo_oe_o) && $past(rd_sel_i) && !$past(sclk_fall))
            |-> $stable(sdo_o));
    // R7: flags forced low until first sample
    assert_flags_low_R7: assert property (@(posedge clk) disable iff (rst)
        !seen_sample |-> (!hold_q.sig_flag && !hold_q.trk_flag));
endmodule

bind rdc_serial_port rdc_serial_port_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_i  (sample_i),
    .rd_sel_i  (rd_sel_i),
    .sdo_o     (sdo_o),
    .sdo_oe_o  (sdo_oe_o),
    .sclk_fall (sclk_fall),
    .hold_q    (hold_q)
);

// File: tb/test_rdc_serial_port.sv
`timescale 1ns/1ps
module test_rdc_serial_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_i = 1'b0;
    logic        rd_sel_i = 1'b0;
    logic        use_vel_i = 1'b0;
    logic        sclk_i = 1'b1;
    logic [11:0] pos_word_i = '0;
    logic [11:0] vel_word_i = '0;
    logic        sig_fault_i = 1'b0;
    logic        trk_fault_i = 1'b0;
    logic        sdo_o, sdo_oe_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rdc_serial_port i_rdc_serial_port (
        .clk(clk), .rst(rst), .sample_i(sample_i), .rd_sel_i(rd_sel_i),
        .use_vel_i(use_vel_i), .sclk_i(sclk_i), .pos_word_i(pos_word_i),
        .vel_word_i(vel_word_i), .sig_fault_i(sig_fault_i),
        .trk_fault_i(trk_fault_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference frame per R2/R3/R4: {word, echo, sig, trk, odd parity}
    function automatic logic [15:0] ref_frame(input logic [11:0] w, input logic v,
                                              input logic s, input logic t);
        logic [14:0] body;
        body = {w, v, s, t};
        return {body, ($countones(body) % 2 == 0) ? 1'b1 : 1'b0};
    endfunction

    // R5: the data line stays low whenever the enable is low
    always @(negedge clk) begin
        if (!rst && !sdo_oe_o) chk("R5 idle line", {31'd0, sdo_o}, 32'd0);
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_sample(input logic [11:0] p, input logic [11:0] v,
                             input logic s, input logic t);
        pos_word_i = p; vel_word_i = v; sig_fault_i = s; trk_fault_i = t;
        sample_i = 1'b1;
        wait_n(1);
        sample_i = 1'b0;
        wait_n(1);
    endtask

    task automatic read_start(input logic uv, input logic [15:0] f, input string tag);
        use_vel_i = uv;
        rd_sel_i = 1'b1;
        wait_n(1);
        chk({tag, " R5 oe rises"}, {31'd0, sdo_oe_o}, 32'd1);
        chk({tag, " R6 MSB before edge"}, {31'd0, sdo_o}, {31'd0, f[15]});
        wait_n(1);
    endtask

    // one serial period; after the falling edge bit idx is expected
    task automatic shift_one(input logic [15:0] f, input int idx, input string tag);
        sclk_i = 1'b0;
        wait_n(4);
        if (idx >= 0) chk({tag, " R2 bit"}, {31'd0, sdo_o}, {31'd0, f[idx]});
        else          chk({tag, " R10 after frame"}, {31'd0, sdo_o}, 32'd0);
        sclk_i = 1'b1;
        wait_n(4);
        if (idx >= 0) chk({tag, " R6 rise no effect"}, {31'd0, sdo_o}, {31'd0, f[idx]});
    endtask

    task automatic read_stop(input string tag);
        rd_sel_i = 1'b0;
        wait_n(1);
        chk({tag, " R5 oe falls"}, {31'd0, sdo_oe_o}, 32'd0);
        wait_n(2);
    endtask

    task automatic full_read(input logic uv, input logic [15:0] f, input string tag);
        read_start(uv, f, tag);
        for (int i = 14; i >= 0; i--) shift_one(f, i, tag);
        shift_one(f, -1, tag);
        shift_one(f, -1, tag);
        read_stop(tag);
    endtask

    initial begin
        logic [15:0] f;
        logic [15:0] g;
        wait_n(3);
        chk("R1 oe in reset", {31'd0, sdo_oe_o}, 32'd0);
        rst = 1'b0;
        wait_n(1);
        chk("R1 oe after reset", {31'd0, sdo_oe_o}, 32'd0);
        chk("R1 sdo after reset", {31'd0, sdo_o}, 32'd0);

        // R1 R7: live inputs busy, no sample yet -> zero words, flags low
        pos_word_i = 12'h5A3; vel_word_i = 12'h777; sig_fault_i = 1; trk_fault_i = 1;
        full_read(1'b0, ref_frame(12'h000, 1'b0, 1'b0, 1'b0), "R1 R7 pre-sample angle");
        full_read(1'b1, ref_frame(12'h000, 1'b1, 1'b0, 1'b0), "R1 R7 pre-sample speed");

        // R2 R4 R7: first sample releases flags
        do_sample(12'hA5C, 12'h3F1, 1'b1, 1'b0);
        full_read(1'b0, ref_frame(12'hA5C, 1'b0, 1'b1, 1'b0), "R2 R4 R7 angle");
        // R3: speed word and echo
        full_read(1'b1, ref_frame(12'h3F1, 1'b1, 1'b1, 1'b0), "R3 speed");

        // R4: dense and sparse patterns
        do_sample(12'hFFF, 12'h001, 1'b1, 1'b1);
        full_read(1'b0, ref_frame(12'hFFF, 1'b0, 1'b1, 1'b1), "R4 all ones");
        full_read(1'b1, ref_frame(12'h001, 1'b1, 1'b1, 1'b1), "R4 sparse");
        do_sample(12'h800, 12'h000, 1'b0, 1'b1);
        full_read(1'b0, ref_frame(12'h800, 1'b0, 1'b0, 1'b1), "R4 msb only");
        full_read(1'b1, ref_frame(12'h000, 1'b1, 1'b0, 1'b1), "R3 R4 zero speed");

        // R8: sample mid-frame must not disturb it
        f = ref_frame(12'h2C7, 1'b0, 1'b0, 1'b0);
        do_sample(12'h2C7, 12'h111, 1'b0, 1'b0);
        read_start(1'b0, f, "R8 mid-sample");
        for (int i = 14; i >= 11; i--) shift_one(f, i, "R8 before");
        do_sample(12'hD38, 12'hEEE, 1'b1, 1'b1);
        for (int i = 10; i >= 0; i--) shift_one(f, i, "R8 after");
        read_stop("R8 mid-sample");
        full_read(1'b0, ref_frame(12'hD38, 1'b0, 1'b1, 1'b1), "R8 next read");

        // R9: abort after five bits, next read restarts at MSB
        g = ref_frame(12'hD38, 1'b0, 1'b1, 1'b1);
        read_start(1'b0, g, "R9 abort");
        for (int i = 14; i >= 10; i--) shift_one(g, i, "R9 partial");
        read_stop("R9 abort");
        full_read(1'b0, g, "R9 restart");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule